// File: doc/BRIEF.md
# Priority-Gated External Interrupt Controller

This block collects level-sensitive interrupt lines and routes them to a set of harts grouped into nodes. Each line owns one pending bit, a two-bit priority held as two separate bit planes, and one enable bit per (node, hart) context. For every context the controller raises a registered request when at least one line is pending, enabled for that context, and has a priority no lower than the privilege level that the hart reports. Privilege levels are encoded as U=0, S=1, H=2, M=3, with M the highest.

Software reaches the controller through a plain 32-bit word bus. The address space opens with twelve read-only words that describe the configuration (dimensions and the byte offset and byte length of each array), so one driver can handle any build of the block. All dimensions are synthesis parameters, and the description words are derived from them.

Word layout, with LW = LINES/32 words per array and contexts numbered ctx = node*HARTS + hart: header words 0..11; pending words at word 12; priority plane 0 after that; priority plane 1 after that; then the enable matrix, LW words per context in ctx order. Bit i%32 of word i/32 of each array belongs to line i.

Top module: `ic_prio_ctrl`

## Requirements
- R1: Header words 0 to 3 read as the line count, node count, hart count and the constant 4 (number of priority levels).
- R2: Header words 4 to 11 read, in pairs of byte offset then byte length, the pending, priority plane 0, priority plane 1 and enable arrays; offsets start at 48 and lengths are LW*4 bytes, except the enable length which is NODES*HARTS*LW*4 bytes.
- R3: Writes to any header word are ignored; the header reads unchanged afterwards.
- R4: A pending bit is set on every clock edge at which its line input is high and stays set after the line falls.
- R5: Writing a 1 to a pending bit clears it unless its line is high in that same cycle; writing 0 leaves it unchanged.
- R6: The priority planes and enable words read back exactly what was last written.
- R7: A line's priority is the two-bit value {plane0 bit, plane1 bit}; it may reach a context only if that value is greater than or equal to the context's privilege input (2 bits per context, context c at bits 2c+1:2c).
- R8: A line reaches a context only if the enable bit for that line in that context's enable words is 1; other contexts are unaffected.
- R9: The request output of a context is registered: it changes on the first clock edge after its privilege input or the stored pending, priority or enable state changes.
- R10: After reset all pending, priority and enable bits are 0 and every request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | LINES | Level-sensitive interrupt lines |
| priv_i | input | 2*NODES*HARTS | Current privilege level per context |
| bus_addr_i | input | ADDR_W | Byte address of the word access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | NODES*HARTS | Registered request per context |

## Verification
The routing function is swept over every combination of line priority and context privilege for each of the four contexts, with exactly one context enabled, which separates a wrong comparison direction, a swapped bit plane or a context decode error. A pending line that is enabled only on a different line position shows that enable bits are matched per line. Single-cycle line pulses against write-1 clears, with and without the line still high, separate set priority from clear priority, and a privilege change sampled just before and just after the clock edge pins the one-cycle request latency.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int HDR_WORDS  = 12;
  localparam int PRIO_LEVELS = 4;
  localparam int HDR_BYTES  = HDR_WORDS * 4;
endpackage

// File: rtl/ic_header.sv
module ic_header #(
  parameter int LINES = 32,
  parameter int NODES = 2,
  parameter int HARTS = 2
) (
  input  logic [3:0]  idx_i,
  output logic [31:0] word_o
);
  import ic_pkg::*;
  localparam int ARR_B = LINES / 8;
  localparam int EN_B  = NODES * HARTS * ARR_B;

  always_comb begin
    case (idx_i)
      4'd0:  word_o = 32'(LINES);
      4'd1:  word_o = 32'(NODES);
      4'd2:  word_o = 32'(HARTS);
      4'd3:  word_o = 32'(PRIO_LEVELS);
      4'd4:  word_o = 32'(HDR_BYTES);
      4'd5:  word_o = 32'(ARR_B);
      4'd6:  word_o = 32'(HDR_BYTES + ARR_B);
      4'd7:  word_o = 32'(ARR_B);
      4'd8:  word_o = 32'(HDR_BYTES + 2 * ARR_B);
      4'd9:  word_o = 32'(ARR_B);
      4'd10: word_o = 32'(HDR_BYTES + 3 * ARR_B);
      4'd11: word_o = 32'(EN_B);
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/ic_regs.sv
module ic_regs #(
  parameter int LINES  = 32,
  parameter int CTX    = 4,
  parameter int WIDX_W = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LINES-1:0]      line_i,
  input  logic                  wr_i,
  input  logic [WIDX_W-1:0]     widx_i,
  input  logic [31:0]           wdata_i,
  input  logic [31:0]           hdr_word_i,
  output logic [LINES-1:0]      pend_o,
  output logic [LINES-1:0]      prio0_o,
  output logic [LINES-1:0]      prio1_o,
  output logic [CTX*LINES-1:0]  en_o,
  output logic [31:0]           rdata_o
);
  import ic_pkg::*;
  localparam int LW      = LINES / 32;
  localparam int PEND_W  = HDR_WORDS;
  localparam int P0_W    = PEND_W + LW;
  localparam int P1_W    = P0_W + LW;
  localparam int EN_W    = P1_W + LW;

  logic [LINES-1:0]     pend_q, pend_d, clr;
  logic [LINES-1:0]     p0_q, p0_d, p1_q, p1_d;
  logic [CTX*LINES-1:0] en_q, en_d;

  // next state
  always_comb begin
    clr  = '0;
    p0_d = p0_q;
    p1_d = p1_q;
    en_d = en_q;
    for (int w = 0; w < LW; w++) begin
      if (wr_i && widx_i == WIDX_W'(PEND_W + w)) clr[w*32 +: 32]  = wdata_i;
      if (wr_i && widx_i == WIDX_W'(P0_W + w))   p0_d[w*32 +: 32] = wdata_i;
      if (wr_i && widx_i == WIDX_W'(P1_W + w))   p1_d[w*32 +: 32] = wdata_i;
      for (int c = 0; c < CTX; c++) begin
        if (wr_i && widx_i == WIDX_W'(EN_W + c * LW + w))
          en_d[c*LINES + w*32 +: 32] = wdata_i;
      end
    end
    // a high line wins over a clear in the same cycle
    pend_d = (pend_q & ~clr) | line_i;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      p0_q   <= '0;
      p1_q   <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      p0_q   <= p0_d;
      p1_q   <= p1_d;
      en_q   <= en_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (widx_i < WIDX_W'(HDR_WORDS)) rdata_o = hdr_word_i;
    for (int w = 0; w < LW; w++) begin
      if (widx_i == WIDX_W'(PEND_W + w)) rdata_o = pend_q[w*32 +: 32];
      if (widx_i == WIDX_W'(P0_W + w))   rdata_o = p0_q[w*32 +: 32];
      if (widx_i == WIDX_W'(P1_W + w))   rdata_o = p1_q[w*32 +: 32];
      for (int c = 0; c < CTX; c++) begin
        if (widx_i == WIDX_W'(EN_W + c * LW + w))
          rdata_o = en_q[c*LINES + w*32 +: 32];
      end
    end
  end

  assign pend_o  = pend_q;
  assign prio0_o = p0_q;
  assign prio1_o = p1_q;
  assign en_o    = en_q;
endmodule

// File: rtl/ic_target.sv
module ic_target #(
  parameter int LINES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] prio0_i,
  input  logic [LINES-1:0] prio1_i,
  input  logic [LINES-1:0] en_i,
  input  logic [1:0]       priv_i,
  output logic             irq_o
);
  logic [LINES-1:0] qual;
  logic             irq_d, irq_q;

  // bit-plane decode: M needs 11, H needs 1x, S needs any 1, U always
  always_comb begin
    case (priv_i)
      2'd3:    qual = prio0_i & prio1_i;
      2'd2:    qual = prio0_i;
      2'd1:    qual = prio0_i | prio1_i;
      default: qual = '1;
    endcase
    irq_d = |(pend_i & en_i & qual);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ic_prio_ctrl.sv
module ic_prio_ctrl #(
  parameter int LINES  = 32,
  parameter int NODES  = 2,
  parameter int HARTS  = 2,
  parameter int ADDR_W = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [LINES-1:0]           line_i,
  input  logic [2*NODES*HARTS-1:0]   priv_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic                       bus_we_i,
  input  logic [31:0]                bus_wdata_i,
  output logic [31:0]                bus_rdata_o,
  output logic [NODES*HARTS-1:0]     irq_o
);
  localparam int CTX    = NODES * HARTS;
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]    widx;
  logic [31:0]          hdr_word;
  logic [LINES-1:0]     pend_w, prio0_w, prio1_w;
  logic [CTX*LINES-1:0] en_w;

  assign widx = bus_addr_i[ADDR_W-1:2];

  ic_header #(.LINES(LINES), .NODES(NODES), .HARTS(HARTS)) u_hdr (
    .idx_i  (widx[3:0]),
    .word_o (hdr_word)
  );

  ic_regs #(.LINES(LINES), .CTX(CTX), .WIDX_W(WIDX_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .wr_i       (bus_we_i),
    .widx_i     (widx),
    .wdata_i    (bus_wdata_i),
    .hdr_word_i (hdr_word),
    .pend_o     (pend_w),
    .prio0_o    (prio0_w),
    .prio1_o    (prio1_w),
    .en_o       (en_w),
    .rdata_o    (bus_rdata_o)
  );

  for (genvar c = 0; c < CTX; c++) begin : g_ctx
    ic_target #(.LINES(LINES)) u_tgt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pend_i  (pend_w),
      .prio0_i (prio0_w),
      .prio1_i (prio1_w),
      .en_i    (en_w[c*LINES +: LINES]),
      .priv_i  (priv_i[2*c +: 2]),
      .irq_o   (irq_o[c])
    );
  end
endmodule

// File: rtl/ic_prio_ctrl_chk.sv
module ic_prio_ctrl_chk #(
  parameter int LINES  = 32,
  parameter int CTX    = 4,
  parameter int ADDR_W = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [LINES-1:0]     line_i,
  input logic [2*CTX-1:0]     priv_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic                 bus_we_i,
  input logic [31:0]          bus_wdata_i,
  input logic [31:0]          bus_rdata_o,
  input logic [CTX-1:0]       irq_o,
  input logic [LINES-1:0]     pend_w,
  input logic [LINES-1:0]     prio0_w,
  input logic [LINES-1:0]     prio1_w
);
  localparam int WIDX_W = ADDR_W - 2;

  p_hdr_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i[ADDR_W-1:2] == '0) |-> (bus_rdata_o == 32'(LINES)));

  for (genvar i = 0; i < LINES; i++) begin : g_line
    p_line_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_i[i] |=> pend_w[i]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i[ADDR_W-1:2] == WIDX_W'(12 + i / 32)
       && bus_wdata_i[i % 32] && !line_i[i]) |=> !pend_w[i]);
  end

  for (genvar c = 0; c < CTX; c++) begin : g_ctx
    p_m_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> $past(priv_i[2*c +: 2] != 2'd3 || |(prio0_w & prio1_w)));
    p_needs_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> $past(|pend_w));
  end
endmodule

bind ic_prio_ctrl ic_prio_ctrl_chk #(.LINES(LINES), .CTX(NODES*HARTS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_i      (line_i),
  .priv_i      (priv_i),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .pend_w      (pend_w),
  .prio0_w     (prio0_w),
  .prio1_w     (prio1_w)
);

// File: tb/ic_prio_ctrl_bench.sv
module ic_prio_ctrl_bench;
  localparam int LINES = 32, NODES = 2, HARTS = 2, ADDR_W = 12;
  localparam int CTX = NODES * HARTS;
  localparam int PEND = 12, P0 = 13, P1 = 14, EN = 15;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [LINES-1:0]  line;
  logic [2*CTX-1:0]  priv;
  logic [ADDR_W-1:0] addr;
  logic              we;
  logic [31:0]       wdata, rdata;
  logic [CTX-1:0]    irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ic_prio_ctrl #(.LINES(LINES), .NODES(NODES), .HARTS(HARTS), .ADDR_W(ADDR_W)) u_ic_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .priv_i(priv),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(w * 4); we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int w, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = ADDR_W'(w * 4);
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] hdr [12];
    hdr = '{32, 2, 2, 4, 48, 4, 52, 4, 56, 4, 60, 16};
    rst_n = 1'b0; line = '0; priv = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    #1 chk(irq == '0, "R10 irq", 32'(irq), 0);
    rd(PEND, 0, "R10 pend"); rd(P0, 0, "R10 prio0"); rd(P1, 0, "R10 prio1");
    for (int c = 0; c < CTX; c++) rd(EN + c, 0, "R10 enable");

    // R1 and R2 header contents
    for (int w = 0; w < 4; w++) rd(w, hdr[w], "R1 header");
    for (int w = 4; w < 12; w++) rd(w, hdr[w], "R2 header");

    // R3 header writes ignored
    for (int w = 0; w < 12; w++) wr(w, 32'hFFFF_FFFF);
    for (int w = 0; w < 12; w++) rd(w, hdr[w], "R3 header after write");

    // R6 read-back
    wr(P0, 32'hA5A5_0F0F); wr(P1, 32'h5A5A_F0F0);
    for (int c = 0; c < CTX; c++) wr(EN + c, 32'h1111_0000 * (c + 1) + c);
    rd(P0, 32'hA5A5_0F0F, "R6 prio0"); rd(P1, 32'h5A5A_F0F0, "R6 prio1");
    for (int c = 0; c < CTX; c++) rd(EN + c, 32'h1111_0000 * (c + 1) + c, "R6 enable");
    wr(P0, 0); wr(P1, 0);
    for (int c = 0; c < CTX; c++) wr(EN + c, 0);

    // R4 set by pulse, held
    @(negedge clk); line[5] = 1'b1; line[31] = 1'b1;
    @(negedge clk); line[5] = 1'b0; line[31] = 1'b0;
    rd(PEND, 32'h8000_0020, "R4 held after pulse");

    // R5 clears
    wr(PEND, 32'h0000_0000);
    rd(PEND, 32'h8000_0020, "R5 write0 no effect");
    wr(PEND, 32'h0000_0020);
    rd(PEND, 32'h8000_0000, "R5 write1 clears");
    @(negedge clk); line[31] = 1'b1;
    wr(PEND, 32'h8000_0000);
    rd(PEND, 32'h8000_0000, "R5 line high beats clear");
    @(negedge clk); line[31] = 1'b0;
    wr(PEND, 32'h8000_0000);
    rd(PEND, 32'h0000_0000, "R5 cleared after line low");

    // R7/R8 sweep: line 7 pending, one context enabled at a time
    @(negedge clk); line[7] = 1'b1;
    for (int c = 0; c < CTX; c++) begin
      for (int c2 = 0; c2 < CTX; c2++) wr(EN + c2, (c2 == c) ? 32'h80 : 32'h0);
      for (int p = 0; p < 4; p++) begin
        wr(P0, (p >= 2) ? 32'h80 : 32'h0);
        wr(P1, (p % 2 == 1) ? 32'h80 : 32'h0);
        for (int v = 0; v < 4; v++) begin
          logic [CTX-1:0] exp;
          @(negedge clk); priv = {CTX{2'(v)}};
          @(negedge clk); @(negedge clk);
          exp = (p >= v) ? CTX'(1 << c) : '0;
          chk(irq == exp, "R7 R8 sweep", 32'(irq), 32'(exp));
        end
      end
    end

    // R8 enable on another line only
    for (int c2 = 0; c2 < CTX; c2++) wr(EN + c2, 32'h100);
    wr(P0, 32'hFFFF_FFFF); wr(P1, 32'hFFFF_FFFF);
    @(negedge clk); priv = '0;
    @(negedge clk); @(negedge clk);
    chk(irq == '0, "R8 other line enabled", 32'(irq), 0);

    // R9 one-cycle latency on privilege change
    wr(EN, 32'h80); wr(P0, 0); wr(P1, 32'h80);
    @(negedge clk); priv = {CTX{2'd3}};
    @(negedge clk); @(negedge clk);
    chk(irq[0] == 1'b0, "R9 masked before", 32'(irq[0]), 0);
    @(negedge clk); priv[1:0] = 2'd0;
    #2 chk(irq[0] == 1'b0, "R9 before edge", 32'(irq[0]), 0);
    @(posedge clk); #1;
    chk(irq[0] == 1'b1, "R9 after edge", 32'(irq[0]), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule